// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit keeps a 64-bit signed running sum and adds a signed product to it each time an operation is strobed. The sum is exposed as two 32-bit words, `acc_hi` (upper) and `acc_lo` (lower). Two products are available. The long product multiplies the full 32-bit operands. The short product multiplies only the lower 16 bits of each operand. Each strobe also carries a saturation enable, and each product type has its own clamping rule.

The operation is registered at the strobe edge and its product is formed. At the next edge the sum is written back and a one-cycle `done` pulse is raised. A new operation may be strobed every cycle. Operations are applied in strobe order. A clear input empties the accumulator. It overrides any operation strobed in the same cycle and any operation still in flight.

Top module: `sat_mac`

## Requirements
- R1: After reset, `acc_hi` and `acc_lo` are zero and `done` is low.
- R2: With `op_word`=0 (long op), the sign-extended product of the full 32-bit `opnd_a` and `opnd_b` is added to the signed 64-bit value {`acc_hi`,`acc_lo`}.
- R3: With `op_word`=1 (short op), only bits 15:0 of each operand are used, each taken as a signed 16-bit number. Bits 31:16 have no effect on the result.
- R4: With `sat_en`=0, both ops wrap modulo 2^64 and no clamping is applied.
- R5: Long op with `sat_en`=1 and a negative 64-bit sum: bits 31:16 of `acc_hi` are forced to ones. The other bits of `acc_hi` and all of `acc_lo` keep the sum.
- R6: Long op with `sat_en`=1 and a non-negative sum: `acc_hi` keeps only its bits 14:0, and `acc_lo` keeps the sum.
- R7: Short op with `sat_en`=1 and a sum below -2^31: the result is `acc_hi`=1 and `acc_lo`=0x80000000.
- R8: Short op with `sat_en`=1 and a sum above 0x7FFFFFFF: the result is `acc_hi`=1 and `acc_lo`=0x7FFFFFFF.
- R9: A strobe is sampled at a rising edge. The accumulator changes and `done` goes high at the second rising edge after it, for exactly one cycle. Strobes in consecutive cycles are all applied, in order.
- R10: `clr` zeroes both accumulator words at the next edge and produces no `done`.
- R11: `clr` has priority over an operation strobed in the same cycle and over one strobed in the cycle before. Neither of those operations changes the accumulator or pulses `done`.
- R12: `op_word` and `sat_en` are taken from the strobe cycle. Changing them afterwards does not affect that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_word | input | 1 | 1 = short 16x16 op, 0 = long 32x32 op |
| sat_en | input | 1 | Saturation enable for the strobed op |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| clr | input | 1 | Clear accumulator, overrides strobes |
| acc_hi | output | 32 | Upper accumulator word |
| acc_lo | output | 32 | Lower accumulator word |
| done | output | 1 | One-cycle pulse on accumulator update |

## Verification
The assertions rebuild the op type and saturation flag of a finished operation from the port values two cycles earlier. They therefore assume that `op_valid`, `op_word`, `sat_en` and `clr` are known (not X) at every edge and are held low while reset is asserted. The stimulus drives every input from time zero, keeps reset asserted for several quiet cycles, and changes inputs only on falling edges. It includes back-to-back strobes with mixed modes, strobes that coincide with a clear, and a clear that lands in the cycle after a strobe, so that the in-flight kill path is checked against the pulse and stability properties.

// File: rtl/sat_mac.sv
module sat_mac #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic         op_word,
  input  logic         sat_en,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         clr,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo,
  output logic         done
);
  localparam int AW = 2 * W;
  localparam int HW = W / 2;
  localparam logic [AW-1:0] LO_LIM = {{(W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [AW-1:0] HI_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [AW-1:0] MARK_LO = {{(W-1){1'b0}}, 2'b11, {(W-1){1'b0}}};
  localparam logic [AW-1:0] MARK_HI = {{(W-1){1'b0}}, 2'b10, {(W-1){1'b1}}};

  logic [AW-1:0] prod_long, prod_word, prod_sel;
  logic          s1_vld, s1_word, s1_sat;
  logic [AW-1:0] s1_prod;
  logic [AW-1:0] acc, sum, nxt;

  assign prod_long = {{W{opnd_a[W-1]}}, opnd_a} * {{W{opnd_b[W-1]}}, opnd_b};
  assign prod_word = {{(AW-HW){opnd_a[HW-1]}}, opnd_a[HW-1:0]}
                   * {{(AW-HW){opnd_b[HW-1]}}, opnd_b[HW-1:0]};
  assign prod_sel  = op_word ? prod_word : prod_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_word <= 1'b0;
      s1_sat  <= 1'b0;
      s1_prod <= '0;
    end else begin
      s1_vld <= op_valid && !clr;
      if (op_valid) begin
        s1_word <= op_word;
        s1_sat  <= sat_en;
        s1_prod <= prod_sel;
      end
    end
  end

  assign sum = acc + s1_prod;

  always_comb begin
    nxt = sum;
    if (s1_sat) begin
      if (!s1_word) begin
        if (sum[AW-1]) nxt[AW-1 -: HW] = '1;
        else           nxt[AW-1 -: HW+1] = '0;
      end else if ($signed(sum) < $signed(LO_LIM)) begin
        nxt = MARK_LO;
      end else if ($signed(sum) > $signed(HI_LIM)) begin
        nxt = MARK_HI;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      done <= 1'b0;
    end else if (clr) begin
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= s1_vld;
      if (s1_vld) acc <= nxt;
    end
  end

  assign acc_hi = acc[AW-1:W];
  assign acc_lo = acc[W-1:0];
endmodule

// File: rtl/sat_mac_chk.sv
module sat_mac_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_word,
  input logic         sat_en,
  input logic         clr,
  input logic [W-1:0] acc_hi,
  input logic [W-1:0] acc_lo,
  input logic         done
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MINL = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXL = {1'b0, {(W-1){1'b1}}};

  assert_done_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && !clr) && !clr |=> done);

  assert_done_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(op_valid && !clr, 2) && !$past(clr));

  assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_hi == '0 && acc_lo == '0 && !done);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !$past(clr) |-> $stable(acc_hi) && $stable(acc_lo));

  assert_long_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(!op_word && sat_en, 2) |->
      (acc_hi[W-1 -: HW] == '1) || (acc_hi[W-1 -: HW+1] == '0));

  assert_word_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(op_word && sat_en, 2) |->
      (acc_hi == '0 && !acc_lo[W-1]) || (acc_hi == '1 && acc_lo[W-1]) ||
      (acc_hi == ONE && (acc_lo == MINL || acc_lo == MAXL)));
endmodule

bind sat_mac sat_mac_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
  .sat_en(sat_en), .clr(clr), .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
);

// File: tb/sat_mac_tb_top.sv
`timescale 1ns/1ps
module sat_mac_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0, clr = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [31:0] acc_hi, acc_lo;
  logic done;

  typedef struct { logic [63:0] val; string tag; } exp_t;
  exp_t sb[$];
  logic [63:0] model = '0;
  int checks = 0, fails = 0;
  bit ended = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  sat_mac dut_i (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .sat_en(sat_en), .opnd_a(opnd_a), .opnd_b(opnd_b), .clr(clr),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done));

  function automatic logic [63:0] mac_model(logic [63:0] acc, bit word, bit sat,
                                            logic [31:0] a, logic [31:0] b);
    longint p, r;
    logic [63:0] u;
    if (word) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    else      p = longint'($signed(a)) * longint'($signed(b));
    r = longint'(acc) + p;
    u = r;
    if (sat && !word) begin
      if (r < 0) u[63:48] = 16'hFFFF;
      else       u[63:47] = '0;
    end else if (sat && word) begin
      if (r < -64'sd2147483648)     u = {32'd1, 32'h8000_0000};
      else if (r > 64'sd2147483647) u = {32'd1, 32'h7FFF_FFFF};
    end
    return u;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // driver: call at a falling edge, returns at the next falling edge
  task automatic drive_op(bit word, bit sat, logic [31:0] a, logic [31:0] b,
                          bit push, string tag);
    exp_t e;
    op_valid = 1; op_word = word; sat_en = sat; opnd_a = a; opnd_b = b;
    if (push) begin
      model = mac_model(model, word, sat, a, b);
      e.val = model; e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    op_valid = 0; op_word = ~word; sat_en = ~sat; opnd_a = ~a; opnd_b = ~b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear(bit with_op, string tag);
    clr = 1;
    if (with_op) begin
      op_valid = 1; op_word = 0; sat_en = 0; opnd_a = 32'd1000; opnd_b = 32'd1000;
    end
    @(negedge clk);
    clr = 0; op_valid = 0;
    model = '0;
    check({acc_hi, acc_lo} == 64'd0, tag, {acc_hi, acc_lo}, 64'd0);
    idle(3);
    check({acc_hi, acc_lo} == 64'd0, tag, {acc_hi, acc_lo}, 64'd0);
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_n && !ended && done) begin
      if (sb.size() == 0) begin
        check(0, "R11 unexpected done", {acc_hi, acc_lo}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({acc_hi, acc_lo} == e.val, e.tag, {acc_hi, acc_lo}, e.val);
      end
    end
  end

  initial begin
    #200_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1;
    @(negedge clk);
    check({acc_hi, acc_lo} == 64'd0 && !done, "R1 reset state", {acc_hi, acc_lo}, 64'd0);

    // R9 latency: one op, done exactly two edges later for one cycle
    drive_op(0, 0, 32'hFFFF_FFFD, 32'd7, 1, "R2 long negative product");
    check(!done, "R9 done early", {63'd0, done}, 64'd0);
    @(negedge clk);
    check(done, "R9 done on second edge", {63'd0, done}, 64'd1);
    @(negedge clk);
    check(!done, "R9 done one cycle", {63'd0, done}, 64'd0);

    drive_op(0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, "R2 long max product");
    drive_op(1, 0, 32'hABCD_8000, 32'h1234_FFFF, 1, "R3 word ignores upper bits");
    drive_op(1, 0, 32'h0000_0005, 32'hFFFF_FFFD, 1, "R3 word signed low halves");
    idle(3);
    do_clear(0, "R10 clear");

    // R4: 2^62 added four times wraps through 2^63 back to zero
    for (int i = 0; i < 4; i++) drive_op(0, 0, 32'h8000_0000, 32'h8000_0000, 1, "R4 wrap");
    idle(3);
    check({acc_hi, acc_lo} == 64'd0, "R4 wrap to zero", {acc_hi, acc_lo}, 64'd0);

    // R6: non-negative long saturate masks hi to 15 bits
    drive_op(0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, "R6 long sat positive");
    idle(3);
    check({acc_hi, acc_lo} == {32'h0000_7FFF, 32'h0000_0001}, "R6 long sat value",
          {acc_hi, acc_lo}, {32'h0000_7FFF, 32'h0000_0001});
    do_clear(0, "R10 clear");

    // R5: negative long saturate forces upper 16 bits of hi
    drive_op(0, 1, 32'h7FFF_FFFF, 32'h8000_0000, 1, "R5 long sat negative");
    idle(3);
    check({acc_hi, acc_lo} == {32'hFFFF_0000, 32'h8000_0000}, "R5 long sat value",
          {acc_hi, acc_lo}, {32'hFFFF_0000, 32'h8000_0000});
    do_clear(0, "R10 clear");

    // R8: positive word overflow, then stays clamped
    for (int i = 0; i < 3; i++) drive_op(1, 1, 32'h5555_8000, 32'h0000_8000, 1, "R8 word sat high");
    idle(3);
    check({acc_hi, acc_lo} == {32'd1, 32'h7FFF_FFFF}, "R8 word sat value",
          {acc_hi, acc_lo}, {32'd1, 32'h7FFF_FFFF});
    do_clear(0, "R10 clear");

    // R7: negative word overflow
    for (int i = 0; i < 3; i++) drive_op(1, 1, 32'h0000_8000, 32'h0000_7FFF, 1, "R7 word sat low");
    idle(3);
    check({acc_hi, acc_lo} == {32'd1, 32'h8000_0000}, "R7 word sat value",
          {acc_hi, acc_lo}, {32'd1, 32'h8000_0000});

    // R11: clear with simultaneous strobe
    do_clear(1, "R11 clear beats strobe");
    // R11: clear in the cycle after a strobe kills it
    drive_op(0, 0, 32'd77, 32'd77, 0, "R11 killed");
    do_clear(0, "R11 clear kills in-flight op");

    // R12 and R9: back-to-back mixed ops, mode inputs flipped after each strobe
    for (int i = 0; i < 60; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      opnd_a = seed;
      seed = seed * 32'd1103515245 + 32'd12345;
      drive_op(seed[7], seed[11], opnd_a, seed, 1, "R12 streamed mixed ops");
    end
    idle(4);
    check(sb.size() == 0, "R9 all results delivered", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule